// File: doc/BRIEF.md
# Burst-of-Two Separate-Port DDR Static Memory

This block is a small, synthesizable model of a static memory that has separate read-data and write-data buses and one shared address bus. Every address holds a pair of words, and each access moves that pair as a two-word burst, one word per half-cycle. The design runs on a single clock in which each tick stands for one half of the memory's K period. A two-bit slot counter, reset to zero, sets the role of each tick. Slot 0 is the K-rising edge that takes a read address. Slot 1 is the following K#-rising edge. Slot 2 is the K-rising edge that takes a write address. Slot 3 is the following K#-rising edge. Because the data buses are separate, reads and writes can be interleaved with no turnaround cycle between them.

A read is accepted when `rd_sel` is high on a slot-0 tick. The two words then appear on `rdata` in order, with `rvalid` high and `echo` toggling once per word. The `lat_long` input is sampled when the read is accepted. When it is high, the first word arrives three ticks after the address (one and a half K cycles). When it is low, the first word arrives two ticks after the address (one K cycle). A write is accepted when `wr_sel` is high on a slot-2 tick. Word 0 is taken from `wdata` on that tick and word 1 on the next tick. A select raised in the wrong K-rising slot is dropped and sets a sticky error flag.

Top module: `dsio_sram`

## Requirements
- R1: After reset `slot_o` is 0, and it advances by one (modulo 4) on every rising clock edge. The codes are: 0 = read-address tick, 1 = K# tick after it, 2 = write-address tick, 3 = K# tick after it.
- R2: A read is accepted only when `rd_sel` is high on a slot-0 tick. A write is accepted only when `wr_sel` is high on a slot-2 tick.
- R3: For an accepted write, `wdata` on the slot-2 tick becomes word 0 at `addr`, and `wdata` on the following slot-3 tick becomes word 1 at the same address.
- R4: With `lat_long` = 1 at acceptance, word 0 of a read is on `rdata` with `rvalid` high after the third rising edge that follows the accepting edge. Word 1 follows one edge later.
- R5: With `lat_long` = 0 at acceptance, word 0 is on `rdata` with `rvalid` high after the second rising edge that follows the accepting edge. Word 1 follows one edge later.
- R6: The latency of a read is set by `lat_long` on its accepting tick. Changing `lat_long` afterwards does not change that read's timing.
- R7: `rvalid` is high for exactly the two word ticks of each burst and low otherwise. While `rvalid` is low, `rdata` holds its last value.
- R8: `echo` toggles with every word driven onto `rdata` and is otherwise stable.
- R9: A read followed by a write to the same address in the same four-tick period returns the newly written words, in both latency modes.
- R10: `rd_sel` on a slot-2 tick and `wr_sel` on a slot-0 tick are ignored: the memory is unchanged and no burst starts. Either one sets `err_o`, which stays high until reset. Selects on slot-1 and slot-3 ticks are ignored and do not set `err_o`.
- R11: During reset, `rdata` = 0, `rvalid` = 0, `echo` = 0 and `err_o` = 0.
- R12: Every address up to the highest, 2^AW-1, stores its own pair. The highest address and address 0 do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period tick clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_long | input | 1 | 1 = one-and-a-half-cycle read latency, 0 = one-cycle read latency |
| rd_sel | input | 1 | Read select, honoured on slot 0 |
| wr_sel | input | 1 | Write select, honoured on slot 2 |
| addr | input | AW | Shared read/write pair address |
| wdata | input | DW | Write data, one word per tick |
| rdata | output | DW | Read data, one word per tick |
| rvalid | output | 1 | High while `rdata` carries a burst word |
| echo | output | 1 | Toggles with each driven read word |
| slot_o | output | 2 | Current tick role (0..3) |
| err_o | output | 1 | Sticky wrong-slot select flag |

## Verification
For a read accepted on rising edge E, the words are due on the ticks after edges E+2 and E+3 in the short mode, and after edges E+3 and E+4 in the long mode. The bench stamps each expected word with that tick number, taken from the `lat_long` value at acceptance, and samples on the falling edge. When a word's tick arrives, the word must be on `rdata` with `rvalid` high and `echo` toggled. On every other tick `rvalid` must be low and `rdata` unchanged. Write effects are checked through later reads. The error flag and `slot_o` are checked at fixed falling edges that lie a known number of ticks after the stimulus.

// File: rtl/dsio_pkg.sv
package dsio_pkg;

    typedef enum logic [1:0] {
        SL_RD_ADDR = 2'd0,
        SL_RD_HALF = 2'd1,
        SL_WR_ADDR = 2'd2,
        SL_WR_HALF = 2'd3
    } slot_e;

    function automatic slot_e slot_next(input slot_e s);
        logic [1:0] v;
        v = s;
        v = v + 2'd1;
        return slot_e'(v);
    endfunction

endpackage

// File: rtl/dsio_slot_ctrl.sv
module dsio_slot_ctrl
    import dsio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_sel,
    input  logic  wr_sel,
    output slot_e slot,
    output logic  rd_acc,
    output logic  wr_acc,
    output logic  err
);

    logic bad_sel;

    assign rd_acc  = rd_sel && (slot == SL_RD_ADDR);
    assign wr_acc  = wr_sel && (slot == SL_WR_ADDR);
    assign bad_sel = (rd_sel && (slot == SL_WR_ADDR)) || (wr_sel && (slot == SL_RD_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SL_RD_ADDR;
            err  <= 1'b0;
        end else begin
            slot <= slot_next(slot);
            if (bad_sel) err <= 1'b1;
        end
    end

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst) err |=> err);
    assert_acc_excl_R2: assert property (@(posedge clk) disable iff (rst) wr_acc |=> !rd_acc);

endmodule

// File: rtl/dsio_wr_capture.sv
module dsio_wr_capture #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_acc,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [1:0]           we,
    output logic [1:0][AW-1:0]   wa,
    output logic [DW-1:0]        wd
);

    logic          hold_v;
    logic [AW-1:0] hold_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_a <= '0;
        end else begin
            hold_v <= wr_acc;
            if (wr_acc) hold_a <= addr;
        end
    end

    assign we[0] = wr_acc;
    assign wa[0] = addr;
    assign we[1] = hold_v;
    assign wa[1] = hold_a;
    assign wd    = wdata;

    assert_second_word_R3: assert property (@(posedge clk) disable iff (rst)
        we[1] |-> ($past(we[0]) && (wa[1] == $past(wa[0]))));

endmodule

// File: rtl/dsio_sram_array.sv
module dsio_sram_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic [1:0]         we,
    input  logic [1:0][AW-1:0] wa,
    input  logic [DW-1:0]      wd,
    input  logic [AW-1:0]      ra,
    output logic [1:0][DW-1:0] rd
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[wa[g]] <= wd;
        end

        assign rd[g] = mem[ra];
    end

endmodule

// File: rtl/dsio_rd_pipe.sv
module dsio_rd_pipe #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int LAT_SHORT = 2,
    parameter int LAT_LONG  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_acc,
    input  logic               lat_long,
    input  logic [AW-1:0]      addr,
    input  logic [1:0][DW-1:0] rd,
    input  logic [1:0]         we,
    input  logic [1:0][AW-1:0] wa,
    input  logic [DW-1:0]      wd,
    output logic [AW-1:0]      ra,
    output logic [DW-1:0]      rdata,
    output logic               rvalid,
    output logic               echo
);

    localparam int SHD = LAT_LONG + 1;

    logic [SHD-1:0]      sh;
    logic                lng;
    logic                ld0, ld1;
    logic [1:0][DW-1:0]  fwd;
    logic [DW-1:0]       out_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            lng <= 1'b0;
            ra  <= '0;
        end else begin
            sh <= {sh[SHD-2:0], rd_acc};
            if (rd_acc) begin
                ra  <= addr;
                lng <= lat_long;
            end
        end
    end

    assign ld0 = lng ? sh[LAT_LONG-1] : sh[LAT_SHORT-1];
    assign ld1 = lng ? sh[LAT_LONG]   : sh[LAT_SHORT];

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            fwd[w] = (we[w] && (wa[w] == ra)) ? wd : rd[w];
        end
        out_d = ld1 ? fwd[1] : fwd[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            echo   <= 1'b0;
        end else begin
            rvalid <= ld0 | ld1;
            if (ld0 | ld1) begin
                rdata <= out_d;
                echo  <= ~echo;
            end
        end
    end

    assert_lat_short_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && !lat_long) |-> ##3 rvalid);
    assert_lat_long_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && lat_long) |-> ##4 rvalid);
    assert_burst_two_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |=> rvalid ##1 !rvalid);
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> $stable(rdata));
    assert_echo_word_R8: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (echo != $past(echo)));
    assert_echo_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> $stable(echo));

endmodule

// File: rtl/dsio_sram.sv
module dsio_sram
    import dsio_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int LAT_SHORT = 2,
    parameter int LAT_LONG  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lat_long,
    input  logic          rd_sel,
    input  logic          wr_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          echo,
    output logic [1:0]    slot_o,
    output logic          err_o
);

    slot_e              slot;
    logic               rd_acc, wr_acc;
    logic [1:0]         we;
    logic [1:0][AW-1:0] wa;
    logic [DW-1:0]      wd;
    logic [AW-1:0]      ra;
    logic [1:0][DW-1:0] rd;

    dsio_slot_ctrl u_slot (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel),
        .slot   (slot),
        .rd_acc (rd_acc),
        .wr_acc (wr_acc),
        .err    (err_o)
    );

    dsio_wr_capture #(.AW(AW), .DW(DW)) u_wr (
        .clk    (clk),
        .rst    (rst),
        .wr_acc (wr_acc),
        .addr   (addr),
        .wdata  (wdata),
        .we     (we),
        .wa     (wa),
        .wd     (wd)
    );

    dsio_sram_array #(.AW(AW), .DW(DW)) u_mem (
        .clk (clk),
        .we  (we),
        .wa  (wa),
        .wd  (wd),
        .ra  (ra),
        .rd  (rd)
    );

    dsio_rd_pipe #(.AW(AW), .DW(DW), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_acc   (rd_acc),
        .lat_long (lat_long),
        .addr     (addr),
        .rd       (rd),
        .we       (we),
        .wa       (wa),
        .wd       (wd),
        .ra       (ra),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .echo     (echo)
    );

    assign slot_o = slot;

    assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(slot_o) == 2'd3) |-> (slot_o == 2'd0));

endmodule

// File: tb/dsio_sram_tb.sv
module dsio_sram_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lat_long = 1'b0;
    logic          rd_sel = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          echo;
    logic [1:0]    slot_o;
    logic          err_o;

    dsio_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .lat_long (lat_long),
        .rd_sel   (rd_sel),
        .wr_sel   (wr_sel),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .echo     (echo),
        .slot_o   (slot_o),
        .err_o    (err_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            due;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] refm [DEPTH][2];
    int            nchk  = 0;
    int            nfail = 0;
    int            tick_n = 0;
    bit            mon_on = 1'b0;
    bit            done   = 1'b0;
    logic          last_echo = 1'b0;
    logic [DW-1:0] last_rdata = '0;

    always @(posedge clk) if (!rst) tick_n <= tick_n + 1;

    task automatic chk(input bit ok, input string msg);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: pops expected words when due, checks idle ticks otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            chk(slot_o == 2'(tick_n % 4),
                $sformatf("R1 slot_o=%0d expected %0d", slot_o, tick_n % 4));
            if (q.size() > 0 && q[0].due == tick_n) begin
                chk(rvalid && rdata == q[0].d && echo != last_echo,
                    $sformatf("%s rdata=%h rvalid=%b echo=%b expected %h rvalid=1 echo=%b",
                              q[0].tag, rdata, rvalid, echo, q[0].d, ~last_echo));
                void'(q.pop_front());
            end else begin
                chk(!rvalid && rdata == last_rdata && echo == last_echo,
                    $sformatf("R7 idle tick rvalid=%b rdata=%h echo=%b expected 0 %h %b",
                              rvalid, rdata, echo, last_rdata, last_echo));
            end
            last_echo  = echo;
            last_rdata = rdata;
        end
    end

    // One four-tick period: optional read on slot 0, optional write on slot 2
    task automatic pair(input bit dr, input logic [AW-1:0] ra, input bit dw,
                        input logic [AW-1:0] wa, input logic [DW-1:0] w0,
                        input logic [DW-1:0] w1, input bit flip, input string tag);
        int e;
        int l;
        e = tick_n;
        if (dw) begin
            refm[wa][0] = w0;
            refm[wa][1] = w1;
        end
        if (dr) begin
            l = lat_long ? 3 : 2;
            q.push_back('{e + l + 1, refm[ra][0], tag});
            q.push_back('{e + l + 2, refm[ra][1], tag});
        end
        rd_sel = dr;
        addr   = ra;
        @(negedge clk);
        rd_sel = 1'b0;
        if (flip) lat_long = ~lat_long;
        @(negedge clk);
        wr_sel = dw;
        addr   = wa;
        wdata  = w0;
        @(negedge clk);
        wr_sel = 1'b0;
        wdata  = w1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rdata == '0 && rvalid == 1'b0 && echo == 1'b0 && err_o == 1'b0 && slot_o == 2'd0,
            $sformatf("R11 reset rdata=%h rvalid=%b echo=%b err=%b slot=%0d expected 0 0 0 0 0",
                      rdata, rvalid, echo, err_o, slot_o));
        rst = 1'b0;
        mon_on = 1'b1;

        // R3 fill every pair, including the top address
        for (int a = 0; a < DEPTH; a++) begin
            pair(1'b0, '0, 1'b1, AW'(a), DW'(a * 7 + 1), DW'(a * 13 + 5) ^ 8'h5A, 1'b0, "R3");
        end

        // R5 short latency, back-to-back reads with writes interleaved; R12 top/zero
        lat_long = 1'b0;
        pair(1'b1, AW'(DEPTH - 1), 1'b0, '0, '0, '0, 1'b0, "R5 R12 top address");
        pair(1'b1, '0, 1'b1, 4'd6, 8'h11, 8'h22, 1'b0, "R5 R12 address zero");
        pair(1'b1, 4'd6, 1'b1, 4'd7, 8'h33, 8'h44, 1'b0, "R5 R3 rewritten pair");
        pair(1'b1, 4'd7, 1'b0, '0, '0, '0, 1'b0, "R5 R3 rewritten pair");

        // R9 same-period read then write, short mode
        pair(1'b1, 4'd5, 1'b1, 4'd5, 8'hC3, 8'h3C, 1'b0, "R9 short mode");

        // R4 long latency
        lat_long = 1'b1;
        pair(1'b1, 4'd2, 1'b1, AW'(DEPTH - 1), 8'hF0, 8'h0F, 1'b0, "R4 long read");
        pair(1'b1, AW'(DEPTH - 1), 1'b0, '0, '0, '0, 1'b0, "R4 R12 top after rewrite");
        pair(1'b1, 4'd9, 1'b1, 4'd9, 8'hA5, 8'h5A, 1'b0, "R9 long mode");

        // R6 latency mode changes after acceptance
        pair(1'b1, 4'd1, 1'b0, '0, '0, '0, 1'b1, "R6 long then flip");
        pair(1'b1, 4'd3, 1'b0, '0, '0, '0, 1'b1, "R6 short then flip");
        lat_long = 1'b0;

        // R10 selects on K# ticks: ignored, no error
        rd_sel = 1'b0;
        @(negedge clk);
        rd_sel = 1'b1; wr_sel = 1'b1; addr = 4'd4; wdata = 8'hEE;
        @(negedge clk);
        rd_sel = 1'b0; wr_sel = 1'b0;
        @(negedge clk);
        rd_sel = 1'b1; wr_sel = 1'b1; addr = 4'd4; wdata = 8'hEE;
        @(negedge clk);
        rd_sel = 1'b0; wr_sel = 1'b0;
        chk(err_o == 1'b0, $sformatf("R10 half-tick selects err_o=%b expected 0", err_o));

        // R10 wrong K-rising slots
        wr_sel = 1'b1; addr = 4'd3; wdata = 8'hFF;
        @(negedge clk);
        wr_sel = 1'b0; wdata = 8'hEE;
        @(negedge clk);
        rd_sel = 1'b1; addr = 4'd4;
        @(negedge clk);
        rd_sel = 1'b0;
        chk(err_o == 1'b1, $sformatf("R10 wrong-slot err_o=%b expected 1", err_o));
        @(negedge clk);
        pair(1'b1, 4'd3, 1'b0, '0, '0, '0, 1'b0, "R10 memory unchanged");
        pair(1'b1, 4'd4, 1'b0, '0, '0, '0, 1'b0, "R10 memory unchanged");
        chk(err_o == 1'b1, $sformatf("R10 sticky err_o=%b expected 1", err_o));
        chk(q.size() > 0, "R2 reads pending before drain");

        repeat (8) @(negedge clk);
        chk(q.size() == 0, $sformatf("R7 undelivered words=%0d expected 0", q.size()));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule